// File: doc/BRIEF.md
# Mixed-Clear Interrupt Status Register

This block holds the interrupt status flags of a selector that hands one downstream bus to one of two masters. Six sources feed six flags:
- a bus-sensor event, raised when a channel switch happens while the bus is busy;
- completion of a bus recovery/initialization sequence;
- a bus-lost event;
- an external active-low interrupt line;
- a local test-interrupt enable;
- a remote-master test-interrupt enable.

An active-low interrupt output is asserted whenever any flag whose mask bit is clear is set.

The flags do not share a clear rule. The three event flags (bus-sensor, recovery-done and bus-lost) clear when the register is read. The clear happens on one particular bit clock of the read data phase. The external-interrupt flag follows its synchronized source and is never cleared by a read, so an input that is still low after a read keeps the interrupt asserted. The two test flags set when their enable bit rises and clear when that bit is cleared. A set event in the same cycle as a read-clear always wins, so no event is lost.

The serial slave logic supplies the read port. It drives a strobe that is high during the read data phase, a one-cycle tick per bit clock, and the index of that bit clock. The mask comes from a control register outside the block.

Top module: `irqstat_top`

## Requirements
- R1: While `rst` is high at a clock edge, `status_o` becomes 8'h00 and `irq_n_o` becomes 1 after that edge.
- R2: The bit layout of `status_o` is as follows. Bit 0 is the external interrupt, bit 1 is recovery-done, bit 2 is the bus-sensor event and bit 3 is bus-lost. Bit 4 is the remote test flag and bit 5 is the local test flag. Bits 7:6 always read 0.
- R3: A one-cycle `sense_evt_i` pulse sets bit 2 after that clock edge, unless `recov_req_i` is high in the same cycle. In that case the pulse is ignored and bit 2 keeps its value.
- R4: A one-cycle `recov_done_i` pulse sets bit 1, and a one-cycle `bus_lost_i` pulse sets bit 3, after that clock edge.
- R5: Bits 1, 2 and 3 clear after the edge at which `rd_strobe_i`=1, `rd_tick_i`=1 and `rd_bitcnt_i`=1 (the second bit clock, counted from 0). A tick at any other count, a tick without the strobe, or the strobe without a tick clears nothing.
- R6: When a set pulse for bit 1, 2 or 3 meets the read-clear in the same cycle, that bit is 1 after the edge.
- R7: `ext_irq_n_i` passes through a two-flop synchronizer. Bit 0 becomes 1 at the third clock edge after the input goes low, and becomes 0 at the third edge after it returns high.
- R8: Bit 5 sets one edge after `test_en_loc_i` is first seen high and clears one edge after it is seen low. Bit 4 does the same with `test_en_rmt_i`. A read clears neither bit.
- R9: `irq_n_o` is the NOR of `status_o[5:0] & ~mask_i`, where mask bit i = 1 masks flag i. It is registered and changes at the same edge as `status_o`, using the `mask_i` value present at that edge.
- R10: If `ext_irq_n_i` stays low through a read sequence, bit 0 remains 1 and, when bit 0 is unmasked, `irq_n_o` stays or returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_evt_i | input | 1 | Pulse: channel switched while bus busy |
| recov_req_i | input | 1 | Level: bus recovery/initialization requested |
| recov_done_i | input | 1 | Pulse: recovery/initialization finished |
| bus_lost_i | input | 1 | Pulse: bus-lost event |
| ext_irq_n_i | input | 1 | Asynchronous active-low external interrupt |
| test_en_loc_i | input | 1 | Local master test-interrupt enable bit |
| test_en_rmt_i | input | 1 | Remote master test-interrupt enable bit |
| mask_i | input | 6 | Per-flag mask, 1 = masked |
| rd_strobe_i | input | 1 | High during the status read data phase |
| rd_tick_i | input | 1 | One-cycle pulse per bit clock of the read |
| rd_bitcnt_i | input | 3 | Index of the current bit clock in the read |
| status_o | output | 8 | Registered status flags |
| irq_n_o | output | 1 | Registered active-low interrupt output |

## Verification
The bench targets the following corner cases:
- **Read-clear timing.** It sends ticks at every bit count, plus a strobe-less tick at count 1. A design that clears on the first bit clock or on the strobe alone would drop flags early.
- **Set colliding with the clearing tick.** It lands a sensor pulse on the clearing tick. A clear-priority design would lose that event.
- **Masked sensor pulse.** It pulses the sensor while recovery is requested. A design that ignores the request would raise bit 2.
- **External input held low across a read.** It holds the external input low through a full read and then toggles its mask. A design that read-clears bit 0 would release the interrupt output while the source is still active.
- **Output and mask alignment.** Mask patterns are changed while several flags are up. An off-by-one-cycle output or an inverted mask shows up as a wrong `irq_n_o`.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;

  // Flag positions inside the status byte
  localparam int FLAG_EXT   = 0;
  localparam int FLAG_RECOV = 1;
  localparam int FLAG_SENSE = 2;
  localparam int FLAG_LOST  = 3;
  localparam int FLAG_TRMT  = 4;
  localparam int FLAG_TLOC  = 5;

  localparam int NUM_FLAGS  = 6;
  localparam int STATUS_W   = 8;

  // How a flag loses its value
  typedef enum logic [1:0] {
    CLR_BY_READ   = 2'd0,
    CLR_BY_SOURCE = 2'd1
  } clr_rule_e;

  function automatic clr_rule_e rule_of(input int idx);
    if (idx == FLAG_RECOV || idx == FLAG_SENSE || idx == FLAG_LOST)
      return CLR_BY_READ;
    return CLR_BY_SOURCE;
  endfunction

endpackage

// File: rtl/irqstat_sync.sv
module irqstat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irqstat_rise.sv
module irqstat_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irqstat_rdclr.sv
module irqstat_rdclr #(
  parameter int CNT_W   = 3,
  parameter int CLR_IDX = 1
) (
  input  logic             rd_strobe_i,
  input  logic             rd_tick_i,
  input  logic [CNT_W-1:0] rd_bitcnt_i,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] CLR_CNT = CNT_W'(CLR_IDX);

  always_comb begin
    clr_o = rd_strobe_i & rd_tick_i & (rd_bitcnt_i == CLR_CNT);
  end
endmodule

// File: rtl/irqstat_flag.sv
module irqstat_flag
  import irqstat_pkg::*;
#(
  parameter clr_rule_e RULE = CLR_BY_READ
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_clr_i,
  input  logic src_gone_i,
  output logic flag_d_o,
  output logic flag_o
);
  logic flag_q;

  generate
    if (RULE == CLR_BY_READ) begin : g_read
      always_comb begin
        if (set_i)         flag_d_o = 1'b1;
        else if (rd_clr_i) flag_d_o = 1'b0;
        else               flag_d_o = flag_q;
      end
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !set_i) |=> !flag_o); // R5
    end else begin : g_src
      always_comb begin
        if (set_i)           flag_d_o = 1'b1;
        else if (src_gone_i) flag_d_o = 1'b0;
        else                 flag_d_o = flag_q;
      end
      AST_SRC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (src_gone_i && !set_i) |=> !flag_o); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d_o;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o); // R6
endmodule

// File: rtl/irqstat_top.sv
module irqstat_top
  import irqstat_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int CLR_IDX     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sense_evt_i,
  input  logic                 recov_req_i,
  input  logic                 recov_done_i,
  input  logic                 bus_lost_i,
  input  logic                 ext_irq_n_i,
  input  logic                 test_en_loc_i,
  input  logic                 test_en_rmt_i,
  input  logic [NUM_FLAGS-1:0] mask_i,
  input  logic                 rd_strobe_i,
  input  logic                 rd_tick_i,
  input  logic [CNT_W-1:0]     rd_bitcnt_i,
  output logic [STATUS_W-1:0]  status_o,
  output logic                 irq_n_o
);
  localparam int PAD_W = STATUS_W - NUM_FLAGS;

  logic                 ext_low;
  logic                 loc_rise, rmt_rise;
  logic                 rd_clr;
  logic [NUM_FLAGS-1:0] set_vec, gone_vec, flag_d, flag_q;
  logic                 irq_n_q;

  irqstat_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (~ext_irq_n_i), .q_o (ext_low)
  );

  irqstat_rise u_rise_loc (
    .clk (clk), .rst (rst), .lvl_i (test_en_loc_i), .rise_o (loc_rise)
  );

  irqstat_rise u_rise_rmt (
    .clk (clk), .rst (rst), .lvl_i (test_en_rmt_i), .rise_o (rmt_rise)
  );

  irqstat_rdclr #(.CNT_W(CNT_W), .CLR_IDX(CLR_IDX)) u_rdclr (
    .rd_strobe_i (rd_strobe_i),
    .rd_tick_i   (rd_tick_i),
    .rd_bitcnt_i (rd_bitcnt_i),
    .clr_o       (rd_clr)
  );

  // Per-flag set and source-gone conditions
  always_comb begin
    set_vec              = '0;
    gone_vec             = '0;
    set_vec[FLAG_EXT]    = ext_low;
    gone_vec[FLAG_EXT]   = ~ext_low;
    set_vec[FLAG_RECOV]  = recov_done_i;
    set_vec[FLAG_SENSE]  = sense_evt_i & ~recov_req_i;
    set_vec[FLAG_LOST]   = bus_lost_i;
    set_vec[FLAG_TRMT]   = rmt_rise;
    gone_vec[FLAG_TRMT]  = ~test_en_rmt_i;
    set_vec[FLAG_TLOC]   = loc_rise;
    gone_vec[FLAG_TLOC]  = ~test_en_loc_i;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    irqstat_flag #(.RULE(rule_of(i))) u_flag (
      .clk        (clk),
      .rst        (rst),
      .set_i      (set_vec[i]),
      .rd_clr_i   (rd_clr),
      .src_gone_i (gone_vec[i]),
      .flag_d_o   (flag_d[i]),
      .flag_o     (flag_q[i])
    );
  end

  // Output registered from next-state so it moves with the flags
  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(flag_d & ~mask_i);
  end

  assign status_o = {{PAD_W{1'b0}}, flag_q};
  assign irq_n_o  = irq_n_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (status_o == '0 && irq_n_o)); // R1
  AST_SENSE_MASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[FLAG_SENSE]) |-> $past(sense_evt_i && !recov_req_i)); // R3
  AST_IRQ_NOR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n_o == !(|(status_o[NUM_FLAGS-1:0] & ~$past(mask_i))))); // R9
  AST_EXT_PERSIST: assert property (@(posedge clk) disable iff (rst)
    (status_o[FLAG_EXT] && ext_low && rd_clr) |=> status_o[FLAG_EXT]); // R10
  AST_TEST_NO_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (status_o[FLAG_TLOC] && test_en_loc_i && rd_clr) |=> status_o[FLAG_TLOC]); // R8
endmodule

// File: tb/irqstat_top_tb.sv
module irqstat_top_tb;
  typedef struct packed { logic [7:0] st; logic irq; } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sense_evt = 0, recov_req = 0, recov_done = 0, bus_lost = 0;
  logic       ext_n = 1, ten_loc = 0, ten_rmt = 0;
  logic [5:0] mask = '0;
  logic       rd_strobe = 0, rd_tick = 0;
  logic [2:0] rd_bitcnt = '0;
  logic [7:0] status;
  logic       irq_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  exp_t  q_exp[$];
  string q_tag[$];

  // reference model state
  logic [5:0] m_fl = '0;
  logic m_s1 = 0, m_s2 = 0, m_ploc = 0, m_prmt = 0;

  always #10 clk = ~clk; // 50 MHz

  irqstat_top u_dut (
    .clk (clk), .rst (rst),
    .sense_evt_i (sense_evt), .recov_req_i (recov_req),
    .recov_done_i (recov_done), .bus_lost_i (bus_lost),
    .ext_irq_n_i (ext_n), .test_en_loc_i (ten_loc), .test_en_rmt_i (ten_rmt),
    .mask_i (mask), .rd_strobe_i (rd_strobe), .rd_tick_i (rd_tick),
    .rd_bitcnt_i (rd_bitcnt), .status_o (status), .irq_n_o (irq_n)
  );

  // Driver: predict the next edge result from the requirements, then wait
  task automatic cyc(input string tag);
    logic [5:0] nx;
    logic rdclr;
    if (rst) begin
      nx = '0;
    end else begin
      rdclr = rd_strobe && rd_tick && (rd_bitcnt == 3'd1);
      nx[0] = m_s2;
      nx[1] = recov_done || (m_fl[1] && !rdclr);
      nx[2] = (sense_evt && !recov_req) || (m_fl[2] && !rdclr);
      nx[3] = bus_lost || (m_fl[3] && !rdclr);
      nx[4] = (ten_rmt && !m_prmt) || (m_fl[4] && ten_rmt);
      nx[5] = (ten_loc && !m_ploc) || (m_fl[5] && ten_loc);
    end
    q_exp.push_back({2'b00, nx, ~|(nx & ~mask)});
    q_tag.push_back(tag);
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_ploc = 0; m_prmt = 0;
    end else begin
      m_s2 = m_s1; m_s1 = ~ext_n; m_ploc = ten_loc; m_prmt = ten_rmt;
    end
    m_fl = nx;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pulse_clear();
    sense_evt = 0; recov_done = 0; bus_lost = 0;
  endtask

  // Full 8-bit read data phase: tick cycle then gap cycle per bit
  task automatic read_seq(input string tag);
    rd_strobe = 1;
    for (int b = 0; b < 8; b++) begin
      rd_bitcnt = 3'(b); rd_tick = 1; cyc(tag);
      rd_tick = 0; cyc(tag);
    end
    rd_strobe = 0; rd_bitcnt = '0;
  endtask

  // Monitor: compare each result after the edge
  always begin
    @(posedge clk);
    #5;
    if (q_exp.size() > 0) begin
      exp_t e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_tests++;
      if (status !== e.st || irq_n !== e.irq) begin
        n_fail++;
        $display("FAIL %s: status=%02h irq_n=%b expected status=%02h irq_n=%b",
                 t, status, irq_n, e.st, e.irq);
      end
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    idle(3, "R1");
    rst = 0;
    idle(2, "R1");

    // R3 sensor event, then masked by recovery request
    sense_evt = 1; cyc("R3"); pulse_clear();
    idle(2, "R3");
    read_seq("R5");
    recov_req = 1; sense_evt = 1; cyc("R3"); pulse_clear();
    idle(2, "R3"); recov_req = 0;

    // R4 / R2 individual sources land in their own bits
    recov_done = 1; cyc("R4"); pulse_clear(); idle(1, "R4");
    bus_lost = 1; cyc("R2"); pulse_clear(); idle(1, "R2");

    // R5 non-clearing read activity
    rd_tick = 1; rd_bitcnt = 3'd1; cyc("R5"); rd_tick = 0;
    rd_strobe = 1; cyc("R5");
    rd_bitcnt = 3'd0; rd_tick = 1; cyc("R5");
    rd_bitcnt = 3'd2; cyc("R5");
    rd_tick = 0; rd_strobe = 0; rd_bitcnt = '0;
    idle(1, "R5");
    read_seq("R5");

    // R6 set collides with the clearing tick
    recov_done = 1; bus_lost = 1; cyc("R6"); pulse_clear();
    rd_strobe = 1; rd_bitcnt = 3'd1; rd_tick = 1; sense_evt = 1; recov_done = 1;
    cyc("R6"); pulse_clear(); rd_tick = 0;
    idle(2, "R6");
    rd_strobe = 0; rd_bitcnt = '0;
    read_seq("R6");

    // R7 / R10 external input with synchronizer latency and read persistence
    ext_n = 0; idle(5, "R7");
    read_seq("R10");
    mask = 6'h01; idle(2, "R9");
    mask = 6'h00; idle(2, "R10");
    ext_n = 1; idle(4, "R7");

    // R8 test enables
    ten_loc = 1; idle(3, "R8");
    read_seq("R8");
    ten_rmt = 1; idle(2, "R8");
    ten_loc = 0; idle(2, "R8");
    ten_rmt = 0; idle(2, "R8");

    // R9 mask patterns with several flags up
    recov_done = 1; bus_lost = 1; sense_evt = 1; cyc("R9"); pulse_clear();
    ten_rmt = 1;
    mask = 6'h3F; idle(2, "R9");
    mask = 6'h0E; idle(2, "R9");
    mask = 6'h10; idle(2, "R9");
    mask = 6'h3E; ext_n = 0; idle(4, "R9");
    read_seq("R9");
    mask = 6'h3F; idle(1, "R9");
    ten_rmt = 0; ext_n = 1; mask = 6'h00; idle(5, "R9");

    idle(2, "R2");
    done = 1;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule